// File: doc/BRIEF.md
# Forward Slice Collection Buffer

This block records, at retirement, the chain of instructions that depend on a load whose value was predicted. When a prediction is made for such a seed load, the block opens a slice in one of its slots and marks the load's destination register as belonging to that slice. From then on every retiring instruction is inspected. An instruction joins the slice if it consumes a marked register, or if it is a load from an address that an earlier slice store wrote. Each member is appended to the slot's instruction buffer and its destination becomes marked. The values of its operands that come from outside the slice are kept as live-ins.

A later replay engine reads the buffered instructions and live-ins through a combinational read port. It uses the per-slot descriptor to decide whether selective replay is possible. The descriptor carries the seed identifier, the counts, a valid bit and an overlap bit. The valid bit is dropped when a buffer would overflow, and the slice then falls back to a normal squash. The overlap bit says that two live slices share an instruction, so they have to be merged and replayed in program order. A correct prediction frees the slot.

Top module: `slc_collect`

## Requirements
- R1: After reset every slot reports valid 0, overlap 0, instruction count 0 and live-in count 0.
- R2: A seed strobe on a slot sets that slot's valid to 1 and loads the seed identifier. It clears the counts and the overlap bit. It replaces the slot's register marks with a single mark on the seed register, and it empties the slot's store-address set.
- R3: A retiring instruction is a member of a valid slot if it has a valid source whose register is marked in that slot. A member is stored at index equal to the current count, with its opcode, destination, both source registers and address, and the count grows by one. Its destination mark in that slot is then set if the destination is valid.
- R4: A retiring instruction that is not a member and writes a valid destination clears that register's mark in the slot. It is not buffered, so later readers of that register do not join.
- R5: Opcodes are 0 ALU, 1 load, 2 store and 3 branch. A member store adds its address to the slot's store-address set. A later load (opcode 1) to an address in that set is a member even when none of its sources is marked.
- R6: For a member, each valid source that is not marked in the slot is saved as a live-in. The register number and value are written at index equal to the live-in count, source 1 before source 2, and the count grows by the number saved.
- R7: An instruction that is a member of two or more valid slots is appended to each of them and sets the overlap bit of each.
- R8: A member that finds 16 instructions already stored, or would raise the live-in count above 8, or is a store to a new address when the set already holds 4 addresses, clears the slot's valid bit. The counts stay frozen and nothing is stored.
- R9: A correct-resolution strobe on a slot clears its valid, overlap and counts. A seed strobe to the same slot in the same cycle takes priority over it, and both take priority over a retiring instruction.
- R10: The read port returns, with no clock delay, the stored instruction fields for the selected slot and index, and the stored live-in register and value for the selected live-in index.
- R11: A retiring instruction in the same cycle as a seed strobe is ignored by the seeded slot and handled normally by the other slots.
- R12: A slot whose valid bit is 0 ignores retiring instructions. Its counts and valid bit do not change until it is seeded or resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_start | input | 1 | A prediction was made: open a slice |
| seed_slot | input | SW | Slot to open |
| seed_id | input | SEEDW | Identifier of the seed load |
| seed_reg | input | RW | Destination register of the seed load |
| resolve_ok | input | 1 | Seed prediction of a slot proved correct |
| resolve_slot | input | SW | Slot being released |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_op | input | 2 | Opcode: 0 ALU, 1 load, 2 store, 3 branch |
| ret_dst | input | RW | Destination register |
| ret_dst_vld | input | 1 | Destination is written |
| ret_src1 | input | RW | First source register |
| ret_src1_vld | input | 1 | First source is used |
| ret_src2 | input | RW | Second source register |
| ret_src2_vld | input | 1 | Second source is used |
| ret_val1 | input | DW | Value of the first source |
| ret_val2 | input | DW | Value of the second source |
| ret_addr | input | AW | Memory address for loads and stores |
| desc_valid | output | NSLICE | Per-slot valid bit |
| desc_overlap | output | NSLICE | Per-slot overlap bit |
| desc_seed | output | NSLICE x SEEDW | Per-slot seed identifier |
| desc_icnt | output | NSLICE x ICW | Per-slot instruction count |
| desc_lcnt | output | NSLICE x LCW | Per-slot live-in count |
| rd_slot | input | SW | Read port slot select |
| rd_idx | input | IW | Read port instruction index |
| rd_op | output | 2 | Stored opcode |
| rd_dst | output | RW | Stored destination |
| rd_src1 | output | RW | Stored first source |
| rd_src2 | output | RW | Stored second source |
| rd_addr | output | AW | Stored address |
| rd_lidx | input | LW | Read port live-in index |
| rd_lreg | output | RW | Stored live-in register |
| rd_lval | output | DW | Stored live-in value |

## Verification
The bench drives each way an instruction can join a slice: through a marked register, through a store-to-load address match, and through both slots at once. A design that missed the memory path would leave the dependent load and everything after it out of the slice. A design that missed the shared case would leave the overlap bit low. It also redefines a marked register with an outside instruction and then reads that register; a design that kept stale marks would buffer the reader. The exact boundaries are hit one by one: the seventeenth instruction, the ninth live-in and the fifth store address. An off-by-one there would either keep the slice valid with a corrupted buffer or drop it one step early. Collisions of a seed strobe with a retire and with a resolve, in the same cycle on the same slot, show whether the priority order is kept.

// File: rtl/slc_pkg.sv
package slc_pkg;
    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_BRANCH = 2'd3
    } slc_op_e;
endpackage

// File: rtl/slc_regtags.sv
module slc_regtags #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic [RW-1:0]   init_reg,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_reg,
    input  logic            wr_bit,
    output logic [NREG-1:0] tags
);
    logic [NREG-1:0] tags_d, tags_q;

    always_comb begin
        tags_d = tags_q;
        if (init) begin
            tags_d           = '0;
            tags_d[init_reg] = 1'b1;
        end else if (wr_en) begin
            tags_d[wr_reg] = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tags_q <= '0;
        else        tags_q <= tags_d;
    end

    assign tags = tags_q;

    AST_SEED_SINGLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> ($countones(tags) == 1)); // R2
endmodule

// File: rtl/slc_storeset.sv
module slc_storeset #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic          ins,
    output logic          hit,
    output logic          full
);
    logic [DEPTH-1:0][AW-1:0] addr_d, addr_q;
    logic [CW-1:0]            cnt_d, cnt_q;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt_q && addr_q[i] == addr) hit = 1'b1;
        end
        full = (cnt_q == CW'(DEPTH));
    end

    always_comb begin
        addr_d = addr_q;
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (ins && !hit && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_q) addr_d[i] = addr;
            end
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
        end
    end

    AST_SET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R8
    AST_SET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !full); // R2
endmodule

// File: rtl/slc_collect.sv
module slc_collect #(
    parameter int NREG   = 32,
    parameter int NSLICE = 2,
    parameter int IDEPTH = 16,
    parameter int LDEPTH = 8,
    parameter int SDEPTH = 4,
    parameter int DW     = 32,
    parameter int AW     = 16,
    parameter int SEEDW  = 8,
    localparam int RW  = $clog2(NREG),
    localparam int SW  = $clog2(NSLICE),
    localparam int IW  = $clog2(IDEPTH),
    localparam int LW  = $clog2(LDEPTH),
    localparam int ICW = $clog2(IDEPTH + 1),
    localparam int LCW = $clog2(LDEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              seed_start,
    input  logic [SW-1:0]                     seed_slot,
    input  logic [SEEDW-1:0]                  seed_id,
    input  logic [RW-1:0]                     seed_reg,
    input  logic                              resolve_ok,
    input  logic [SW-1:0]                     resolve_slot,
    input  logic                              ret_valid,
    input  logic [1:0]                        ret_op,
    input  logic [RW-1:0]                     ret_dst,
    input  logic                              ret_dst_vld,
    input  logic [RW-1:0]                     ret_src1,
    input  logic                              ret_src1_vld,
    input  logic [RW-1:0]                     ret_src2,
    input  logic                              ret_src2_vld,
    input  logic [DW-1:0]                     ret_val1,
    input  logic [DW-1:0]                     ret_val2,
    input  logic [AW-1:0]                     ret_addr,
    output logic [NSLICE-1:0]                 desc_valid,
    output logic [NSLICE-1:0]                 desc_overlap,
    output logic [NSLICE-1:0][SEEDW-1:0]      desc_seed,
    output logic [NSLICE-1:0][ICW-1:0]        desc_icnt,
    output logic [NSLICE-1:0][LCW-1:0]        desc_lcnt,
    input  logic [SW-1:0]                     rd_slot,
    input  logic [IW-1:0]                     rd_idx,
    output logic [1:0]                        rd_op,
    output logic [RW-1:0]                     rd_dst,
    output logic [RW-1:0]                     rd_src1,
    output logic [RW-1:0]                     rd_src2,
    output logic [AW-1:0]                     rd_addr,
    input  logic [LW-1:0]                     rd_lidx,
    output logic [RW-1:0]                     rd_lreg,
    output logic [DW-1:0]                     rd_lval
);
    import slc_pkg::*;

    typedef struct packed {
        logic [1:0]    op;
        logic [RW-1:0] dst;
        logic [RW-1:0] src1;
        logic [RW-1:0] src2;
        logic [AW-1:0] addr;
    } ient_t;

    typedef struct packed {
        logic [RW-1:0] lreg;
        logic [DW-1:0] val;
    } lent_t;

    typedef struct packed {
        logic                     valid;
        logic                     overlap;
        logic [SEEDW-1:0]         seed;
        logic [ICW-1:0]           icnt;
        logic [LCW-1:0]           lcnt;
        ient_t [IDEPTH-1:0]       ib;
        lent_t [LDEPTH-1:0]       lb;
    } slot_t;

    slot_t [NSLICE-1:0] st_d, st_q;

    logic [NREG-1:0]    tags [NSLICE];
    logic [NSLICE-1:0]  ss_hit, ss_full, ss_ins;
    logic [NSLICE-1:0]  seeded, resolved, live, t1, t2, member, ovf, tag_we;
    logic [LCW:0]       need_l [NSLICE];
    logic               multi;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slot
        slc_regtags #(.NREG(NREG)) u_tags (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (seeded[s]),
            .init_reg(seed_reg),
            .wr_en   (tag_we[s]),
            .wr_reg  (ret_dst),
            .wr_bit  (member[s]),
            .tags    (tags[s])
        );

        slc_storeset #(.AW(AW), .DEPTH(SDEPTH)) u_sset (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(seeded[s]),
            .addr (ret_addr),
            .ins  (ss_ins[s]),
            .hit  (ss_hit[s]),
            .full (ss_full[s])
        );

        assign desc_valid[s]   = st_q[s].valid;
        assign desc_overlap[s] = st_q[s].overlap;
        assign desc_seed[s]    = st_q[s].seed;
        assign desc_icnt[s]    = st_q[s].icnt;
        assign desc_lcnt[s]    = st_q[s].lcnt;

        AST_SEED_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
            (seed_start && seed_slot == SW'(s)) |=>
            (desc_valid[s] && desc_icnt[s] == '0 && desc_lcnt[s] == '0 && !desc_overlap[s])); // R2
        AST_RESOLVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (resolve_ok && resolve_slot == SW'(s) && !(seed_start && seed_slot == SW'(s)))
            |=> !desc_valid[s]); // R9
        AST_ICNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (desc_valid[s] && !(seed_start && seed_slot == SW'(s))
             && !(resolve_ok && resolve_slot == SW'(s)))
            |=> ((desc_icnt[s] - $past(desc_icnt[s])) <= ICW'(1))); // R3
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (desc_icnt[s] <= ICW'(IDEPTH)) && (desc_lcnt[s] <= LCW'(LDEPTH))); // R8
        AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (!desc_valid[s] && !(seed_start && seed_slot == SW'(s))
             && !(resolve_ok && resolve_slot == SW'(s)))
            |=> (!desc_valid[s] && $stable(desc_icnt[s]) && $stable(desc_lcnt[s]))); // R12
    end

    // Membership, live-in demand and overflow for each slot.
    always_comb begin
        for (int s = 0; s < NSLICE; s++) begin
            seeded[s]   = seed_start && (seed_slot == SW'(s));
            resolved[s] = resolve_ok && (resolve_slot == SW'(s));
            live[s]     = st_q[s].valid && ret_valid && !seeded[s];
            t1[s]       = ret_src1_vld && tags[s][ret_src1];
            t2[s]       = ret_src2_vld && tags[s][ret_src2];
            member[s]   = live[s] && (t1[s] || t2[s]
                          || (slc_op_e'(ret_op) == OP_LOAD && ss_hit[s]));
            need_l[s]   = (LCW+1)'(ret_src1_vld && !t1[s])
                        + (LCW+1)'(ret_src2_vld && !t2[s]);
            ovf[s]      = member[s] && ((st_q[s].icnt == ICW'(IDEPTH))
                          || (({1'b0, st_q[s].lcnt} + need_l[s]) > (LCW+1)'(LDEPTH))
                          || (slc_op_e'(ret_op) == OP_STORE && !ss_hit[s] && ss_full[s]));
            tag_we[s]   = live[s] && ret_dst_vld && !ovf[s];
            ss_ins[s]   = member[s] && !ovf[s] && slc_op_e'(ret_op) == OP_STORE;
        end
        multi = ($countones(member) > 1);
    end

    // Next state of every slot.
    always_comb begin
        logic [LCW-1:0] lpos;
        st_d = st_q;
        lpos = '0;
        for (int s = 0; s < NSLICE; s++) begin
            if (seeded[s]) begin
                st_d[s].valid   = 1'b1;
                st_d[s].overlap = 1'b0;
                st_d[s].seed    = seed_id;
                st_d[s].icnt    = '0;
                st_d[s].lcnt    = '0;
            end else if (resolved[s]) begin
                st_d[s].valid   = 1'b0;
                st_d[s].overlap = 1'b0;
                st_d[s].icnt    = '0;
                st_d[s].lcnt    = '0;
            end else if (member[s]) begin
                if (ovf[s]) begin
                    st_d[s].valid = 1'b0;
                end else begin
                    for (int i = 0; i < IDEPTH; i++) begin
                        if (ICW'(i) == st_q[s].icnt)
                            st_d[s].ib[i] = {ret_op, ret_dst, ret_src1, ret_src2, ret_addr};
                    end
                    st_d[s].icnt = st_q[s].icnt + ICW'(1);
                    lpos = st_q[s].lcnt;
                    if (ret_src1_vld && !t1[s]) begin
                        for (int j = 0; j < LDEPTH; j++) begin
                            if (LCW'(j) == lpos) st_d[s].lb[j] = {ret_src1, ret_val1};
                        end
                        lpos = lpos + LCW'(1);
                    end
                    if (ret_src2_vld && !t2[s]) begin
                        for (int j = 0; j < LDEPTH; j++) begin
                            if (LCW'(j) == lpos) st_d[s].lb[j] = {ret_src2, ret_val2};
                        end
                        lpos = lpos + LCW'(1);
                    end
                    st_d[s].lcnt = lpos;
                    if (multi) st_d[s].overlap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_op   = st_q[rd_slot].ib[rd_idx].op;
    assign rd_dst  = st_q[rd_slot].ib[rd_idx].dst;
    assign rd_src1 = st_q[rd_slot].ib[rd_idx].src1;
    assign rd_src2 = st_q[rd_slot].ib[rd_idx].src2;
    assign rd_addr = st_q[rd_slot].ib[rd_idx].addr;
    assign rd_lreg = st_q[rd_slot].lb[rd_lidx].lreg;
    assign rd_lval = st_q[rd_slot].lb[rd_lidx].val;
endmodule

// File: tb/tb_slc_collect.sv
module tb_slc_collect;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seed_start = 0; logic [0:0] seed_slot = 0; logic [7:0] seed_id = 0; logic [4:0] seed_reg = 0;
    logic resolve_ok = 0; logic [0:0] resolve_slot = 0;
    logic ret_valid = 0; logic [1:0] ret_op = 0; logic [4:0] ret_dst = 0; logic ret_dst_vld = 0;
    logic [4:0] ret_src1 = 0; logic ret_src1_vld = 0; logic [4:0] ret_src2 = 0; logic ret_src2_vld = 0;
    logic [31:0] ret_val1 = 0, ret_val2 = 0; logic [15:0] ret_addr = 0;
    logic [1:0] desc_valid, desc_overlap;
    logic [1:0][7:0] desc_seed; logic [1:0][4:0] desc_icnt; logic [1:0][3:0] desc_lcnt;
    logic [0:0] rd_slot = 0; logic [3:0] rd_idx = 0; logic [2:0] rd_lidx = 0;
    logic [1:0] rd_op; logic [4:0] rd_dst, rd_src1, rd_src2, rd_lreg; logic [15:0] rd_addr; logic [31:0] rd_lval;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // Reference state built from the requirements.
    bit mtag [2][32];
    int mset [2][4]; int mscnt [2];
    bit mval [2], movl [2]; int mseed [2], micnt [2], mlcnt [2];
    int ib_op [2][16], ib_dst [2][16], ib_s1 [2][16], ib_s2 [2][16], ib_ad [2][16];
    int lb_reg [2][8]; logic [31:0] lb_val [2][8];

    slc_collect dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit in_set(int s, int a);
        for (int k = 0; k < mscnt[s]; k++) if (mset[s][k] == a) return 1;
        return 0;
    endfunction

    function automatic void model_step();
        bit mem [2]; bit a1 [2]; bit a2 [2]; bit of [2]; bit hit [2]; bit lv [2];
        int nm = 0;
        for (int s = 0; s < 2; s++) begin
            bit sd = seed_start && seed_slot == s;
            int need;
            lv[s]  = mval[s] && ret_valid && !sd;
            a1[s]  = ret_src1_vld && mtag[s][ret_src1];
            a2[s]  = ret_src2_vld && mtag[s][ret_src2];
            hit[s] = in_set(s, ret_addr);
            mem[s] = lv[s] && (a1[s] || a2[s] || (ret_op == 1 && hit[s]));
            need   = int'(ret_src1_vld && !a1[s]) + int'(ret_src2_vld && !a2[s]);
            of[s]  = mem[s] && (micnt[s] == 16 || mlcnt[s] + need > 8
                     || (ret_op == 2 && !hit[s] && mscnt[s] == 4));
            if (mem[s]) nm++;
        end
        for (int s = 0; s < 2; s++) begin
            bit sd = seed_start && seed_slot == s;
            bit rs = resolve_ok && resolve_slot == s;
            if (sd) begin
                for (int r = 0; r < 32; r++) mtag[s][r] = 0;
                mtag[s][seed_reg] = 1; mscnt[s] = 0;
            end else begin
                if (lv[s] && ret_dst_vld && !of[s]) mtag[s][ret_dst] = mem[s];
                if (mem[s] && !of[s] && ret_op == 2 && !hit[s]) begin
                    mset[s][mscnt[s]] = ret_addr; mscnt[s]++;
                end
            end
            if (sd) begin
                mval[s] = 1; movl[s] = 0; mseed[s] = seed_id; micnt[s] = 0; mlcnt[s] = 0;
            end else if (rs) begin
                mval[s] = 0; movl[s] = 0; micnt[s] = 0; mlcnt[s] = 0;
            end else if (mem[s]) begin
                if (of[s]) mval[s] = 0;
                else begin
                    ib_op[s][micnt[s]] = ret_op; ib_dst[s][micnt[s]] = ret_dst;
                    ib_s1[s][micnt[s]] = ret_src1; ib_s2[s][micnt[s]] = ret_src2;
                    ib_ad[s][micnt[s]] = ret_addr; micnt[s]++;
                    if (ret_src1_vld && !a1[s]) begin
                        lb_reg[s][mlcnt[s]] = ret_src1; lb_val[s][mlcnt[s]] = ret_val1; mlcnt[s]++;
                    end
                    if (ret_src2_vld && !a2[s]) begin
                        lb_reg[s][mlcnt[s]] = ret_src2; lb_val[s][mlcnt[s]] = ret_val2; mlcnt[s]++;
                    end
                    if (nm > 1) movl[s] = 1;
                end
            end
        end
    endfunction

    task automatic check_desc();
        for (int s = 0; s < 2; s++) begin
            chk(cur_req, desc_valid[s], mval[s], $sformatf("slot%0d valid", s));
            chk(cur_req, desc_overlap[s], movl[s], $sformatf("slot%0d overlap", s));
            chk(cur_req, desc_icnt[s], micnt[s], $sformatf("slot%0d icnt", s));
            chk(cur_req, desc_lcnt[s], mlcnt[s], $sformatf("slot%0d lcnt", s));
            if (mval[s]) chk(cur_req, desc_seed[s], mseed[s], $sformatf("slot%0d seed", s));
        end
    endtask

    // R10: combinational read port against stored model contents
    task automatic check_bufs();
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < micnt[s]; i++) begin
                rd_slot = s[0:0]; rd_idx = i[3:0]; #1;
                chk("R10", {rd_op, rd_dst, rd_src1, rd_src2, rd_addr},
                    {ib_op[s][i][1:0], ib_dst[s][i][4:0], ib_s1[s][i][4:0], ib_s2[s][i][4:0],
                     ib_ad[s][i][15:0]}, $sformatf("slot%0d entry%0d", s, i));
            end
            for (int j = 0; j < mlcnt[s]; j++) begin
                rd_slot = s[0:0]; rd_lidx = j[2:0]; #1;
                chk("R10", rd_lreg, lb_reg[s][j], $sformatf("slot%0d livein%0d reg", s, j));
                chk("R10", rd_lval, lb_val[s][j], $sformatf("slot%0d livein%0d val", s, j));
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_desc();
        seed_start = 0; resolve_ok = 0; ret_valid = 0;
    endtask

    task automatic seed(input int slot, input int id, input int r);
        seed_start = 1; seed_slot = slot[0:0]; seed_id = id[7:0]; seed_reg = r[4:0];
    endtask

    task automatic retire(input int op, input int d, input bit dv, input int s1, input bit v1,
                          input int s2, input bit v2, input int a);
        ret_valid = 1; ret_op = op[1:0]; ret_dst = d[4:0]; ret_dst_vld = dv;
        ret_src1 = s1[4:0]; ret_src1_vld = v1; ret_src2 = s2[4:0]; ret_src2_vld = v2;
        ret_val1 = $urandom; ret_val2 = $urandom; ret_addr = a[15:0];
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int s = 0; s < 2; s++) begin
            mval[s] = 0; movl[s] = 0; mseed[s] = 0; micnt[s] = 0; mlcnt[s] = 0; mscnt[s] = 0;
            for (int r = 0; r < 32; r++) mtag[s][r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; check_desc();

        cur_req = "R2"; seed(0, 8'h11, 3); cycle();
        cur_req = "R3"; retire(0, 4, 1, 3, 1, 5, 1, 0); cycle();          // R6: src2 live-in
        chk("R6", desc_lcnt[0], 1, "one live-in saved");
        cur_req = "R4"; retire(0, 6, 1, 7, 1, 8, 1, 0); cycle();
        retire(0, 4, 1, 9, 1, 0, 0, 0); cycle();                          // outsider redefines r4
        retire(0, 10, 1, 4, 1, 0, 0, 0); cycle();
        chk("R4", desc_icnt[0], 1, "reader of cleared tag not buffered");
        cur_req = "R5"; retire(2, 0, 0, 3, 1, 11, 1, 16'h40); cycle();
        retire(1, 12, 1, 9, 1, 0, 0, 16'h40); cycle();
        chk("R5", desc_icnt[0], 3, "load from slice-stored address joined");
        retire(1, 13, 1, 9, 1, 0, 0, 16'h44); cycle();
        chk("R5", desc_icnt[0], 3, "load from other address ignored");
        cur_req = "R3"; retire(0, 14, 1, 12, 1, 0, 0, 0); cycle();
        check_bufs();

        cur_req = "R7"; seed(1, 8'h22, 20); cycle();
        retire(0, 15, 1, 3, 1, 20, 1, 0); cycle();
        chk("R7", desc_overlap, 2'b11, "overlap set in both slots");
        cur_req = "R11"; seed(1, 8'h23, 21); retire(0, 16, 1, 20, 1, 3, 1, 0); cycle();
        chk("R11", desc_icnt[1], 0, "seeded slot ignored same-cycle retire");
        check_bufs();

        cur_req = "R9"; resolve_ok = 1; resolve_slot = 0; cycle();
        chk("R9", desc_valid[0], 0, "resolve clears slot");
        cur_req = "R12"; retire(0, 17, 1, 3, 1, 0, 0, 0); cycle();
        chk("R12", desc_icnt[0], 0, "invalid slot ignores retire");
        cur_req = "R9"; seed(0, 8'h31, 1); resolve_ok = 1; resolve_slot = 0; cycle();
        chk("R9", desc_valid[0], 1, "seed beats resolve");

        cur_req = "R8";
        for (int i = 0; i < 16; i++) begin retire(0, 1, 1, 1, 1, 0, 0, 0); cycle(); end
        chk("R8", desc_valid[0], 1, "16 entries still valid");
        retire(0, 1, 1, 1, 1, 0, 0, 0); cycle();
        chk("R8", {desc_valid[0], desc_icnt[0]}, {1'b0, 5'd16}, "17th entry invalidates");
        seed(0, 8'h32, 1); cycle();
        for (int i = 0; i < 8; i++) begin retire(0, 1, 1, 1, 1, 2, 1, 0); cycle(); end
        chk("R8", {desc_valid[0], desc_lcnt[0]}, {1'b1, 4'd8}, "8 live-ins still valid");
        retire(0, 1, 1, 1, 1, 2, 1, 0); cycle();
        chk("R8", {desc_valid[0], desc_lcnt[0]}, {1'b0, 4'd8}, "9th live-in invalidates");
        seed(0, 8'h33, 1); cycle();
        for (int i = 0; i < 4; i++) begin retire(2, 0, 0, 1, 1, 0, 0, 16'h100 + i); cycle(); end
        retire(2, 0, 0, 1, 1, 0, 0, 16'h101); cycle();
        chk("R8", desc_valid[0], 1, "repeat store address kept");
        retire(2, 0, 0, 1, 1, 0, 0, 16'h200); cycle();
        chk("R8", desc_valid[0], 0, "fifth store address invalidates");

        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 29) == 0) seed($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 7));
            if ($urandom_range(0, 49) == 0) begin resolve_ok = 1; resolve_slot = 1'($urandom_range(0, 1)); end
            if ($urandom_range(0, 9) < 7) begin
                int op = $urandom_range(0, 3);
                retire(op, $urandom_range(0, 7), op < 2, $urandom_range(0, 7), $urandom_range(0, 3) != 0,
                       $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 5));
            end
            cycle();
            if (n % 97 == 0) check_bufs();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule